// File: doc/BRIEF.md
# Processor Run/Stop Controller

This block keeps a bitmap of which processors in a cluster are running, and lets software start or halt any subset of them through a small register bus. Two write-only request registers exist. A run register sets bits and a stop register clears them. A read-only status register returns the bitmap. Each request acts only on the processors whose state actually changes. A processor that becomes running gets a one-cycle wake pulse, and a processor that becomes halted gets a one-cycle halt pulse. These pulses drive the cores' own start and stop sequencing.

The three registers can be reached through two address windows: a local-cluster window at 0x2000 and an other-core window at 0x4000. Inside each window the run register is at +0x0, the stop register at +0x8 and the status register at +0x10. On reset the bitmap is cleared. In the first cycle after reset is released, a configured start set is applied exactly like a run write, so those processors receive wake pulses. The bus takes one request per cycle. A read answers one cycle after it is accepted.

Top module: `runstop_ctrl`

## Requirements
- R1: While reset is asserted, wakePulse, haltPulse and rspValid are all zero and reqReady is low.
- R2: In the first clock edge after reset is released, the bitmap takes START_SET masked to the valid processors, and wakePulse shows those same bits for one cycle. reqReady is high from then on.
- R3: A write accepted at 0x2000 or 0x4000 sets the running bits named in the data. On the next cycle, wakePulse holds exactly the named bits that were not already running.
- R4: A write accepted at 0x2008 or 0x4008 clears the running bits named in the data. On the next cycle, haltPulse holds exactly the named bits that were running.
- R5: Data bits at or above NUM_VP are discarded from every run and stop write. Such bits never appear in the bitmap or in any pulse.
- R6: A read accepted at 0x2010 or 0x4010 raises rspValid for one cycle on the next cycle, with rspRdata equal to the bitmap before that edge. Writes never raise rspValid.
- R7: The local window (0x2000) and the other-core window (0x4000) act on the same bitmap. A change made through one window is seen through the other.
- R8: A read at any other address returns zero with rspValid. A write at any other address changes neither the bitmap nor any pulse.
- R9: wakePulse and haltPulse last a single cycle. They are zero in a cycle that follows no state change.
- R10: A START_SET with any bit at or above NUM_VP is rejected during elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 64 | Write data, one bit per processor |
| rspValid | output | 1 | Read data valid, one cycle after a read is accepted |
| rspRdata | output | 64 | Read data |
| wakePulse | output | 64 | One-cycle wake request per processor |
| haltPulse | output | 64 | One-cycle halt request per processor |

## Verification
The bench uses six processors with a start set of 0b000101. This shows that the start set is applied with wake pulses after reset. Run writes mix already-running and idle processors, so a pulse on a processor that was already running is caught. Stop writes likewise name processors that are idle. All-ones data and data with only high bits set show whether masking at NUM_VP holds. The same operations are issued through both windows, which shows that the windows share one bitmap. Reads and writes to unmapped addresses, each followed by a status read, separate "ignored" from "partly decoded".

// File: rtl/runstop_pkg.sv
package runstop_pkg;

  localparam int DATA_W = 64;

  localparam logic [15:0] LOCAL_BASE = 16'h2000;
  localparam logic [15:0] OTHER_BASE = 16'h4000;
  localparam logic [15:0] OFS_RUN    = 16'h0000;
  localparam logic [15:0] OFS_STOP   = 16'h0008;
  localparam logic [15:0] OFS_STATUS = 16'h0010;

  // Strobes from control to datapath
  typedef struct packed {
    logic preload;
    logic runStb;
    logic stopStb;
    logic statusRd;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] vpMask(input int n);
    if (n >= DATA_W) return '1;
    return (DATA_W'(1) << n) - DATA_W'(1);
  endfunction

endpackage

// File: rtl/runstop_control.sv
module runstop_control
  import runstop_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output ctrl_t             ctrl
);

  localparam logic [ADDR_W-1:0] A_RUN_L  = ADDR_W'(LOCAL_BASE + OFS_RUN);
  localparam logic [ADDR_W-1:0] A_RUN_O  = ADDR_W'(OTHER_BASE + OFS_RUN);
  localparam logic [ADDR_W-1:0] A_STOP_L = ADDR_W'(LOCAL_BASE + OFS_STOP);
  localparam logic [ADDR_W-1:0] A_STOP_O = ADDR_W'(OTHER_BASE + OFS_STOP);
  localparam logic [ADDR_W-1:0] A_STAT_L = ADDR_W'(LOCAL_BASE + OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_STAT_O = ADDR_W'(OTHER_BASE + OFS_STATUS);

  logic initDone;
  logic accept;
  logic hitRun, hitStop, hitStatus;

  assign reqReady  = initDone;
  assign accept    = reqValid && reqReady;
  assign hitRun    = (reqAddr == A_RUN_L)  || (reqAddr == A_RUN_O);
  assign hitStop   = (reqAddr == A_STOP_L) || (reqAddr == A_STOP_O);
  assign hitStatus = (reqAddr == A_STAT_L) || (reqAddr == A_STAT_O);

  always_comb begin
    ctrl.preload  = rstN && !initDone;
    ctrl.runStb   = accept && reqWrite && hitRun;
    ctrl.stopStb  = accept && reqWrite && hitStop;
    ctrl.statusRd = accept && !reqWrite && hitStatus;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initDone <= 1'b0;
      rspValid <= 1'b0;
    end else begin
      initDone <= 1'b1;
      rspValid <= accept && !reqWrite;
    end
  end

  // R6: a response only ever follows an accepted read
  a_r6_rsp_after_read: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && reqReady && !reqWrite));

  // R2: the bus is held off for one cycle only, for the start-set preload
  a_r2_ready_after_preload: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> reqReady);

  // R3/R4: run and stop strobes are exclusive
  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.runStb && ctrl.stopStb));

endmodule

// File: rtl/runstop_datapath.sv
module runstop_datapath
  import runstop_pkg::*;
#(
  parameter int              NUM_VP    = 1,
  parameter logic [DATA_W-1:0] START_SET = 64'h1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] running,
  output logic [DATA_W-1:0] wakePulse,
  output logic [DATA_W-1:0] haltPulse,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [DATA_W-1:0] VP_MASK = vpMask(NUM_VP);

  logic [DATA_W-1:0] setReq, clrReq, newWake, newHalt;

  always_comb begin
    if (ctrl.preload)     setReq = START_SET & VP_MASK;
    else if (ctrl.runStb) setReq = wdata & VP_MASK;
    else                  setReq = '0;
    clrReq  = ctrl.stopStb ? (wdata & VP_MASK) : '0;
    newWake = setReq & ~running;
    newHalt = clrReq & running;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= '0;
      wakePulse <= '0;
      haltPulse <= '0;
      rdata     <= '0;
    end else begin
      running   <= (running | setReq) & ~clrReq;
      wakePulse <= newWake;
      haltPulse <= newHalt;
      rdata     <= ctrl.statusRd ? running : '0;
    end
  end

  // R3: a wake pulse never names a processor that was already running
  a_r3_wake_only_new: assert property (@(posedge clk) disable iff (!rstN)
    (wakePulse & $past(running)) == '0);

  // R3: every woken processor is now running
  a_r3_woken_running: assert property (@(posedge clk) disable iff (!rstN)
    (running & wakePulse) == wakePulse);

  // R4: a halt pulse only names processors that were running, now stopped
  a_r4_halt_only_running: assert property (@(posedge clk) disable iff (!rstN)
    ((haltPulse & ~$past(running)) == '0) && ((haltPulse & running) == '0));

  // R5: nothing outside the valid processors is ever set
  a_r5_mask: assert property (@(posedge clk) disable iff (!rstN)
    ((running | wakePulse | haltPulse) & ~VP_MASK) == '0);

endmodule

// File: rtl/runstop_ctrl.sv
module runstop_ctrl
  import runstop_pkg::*;
#(
  parameter int                NUM_VP    = 1,
  parameter logic [DATA_W-1:0] START_SET = 64'h1,
  parameter int                ADDR_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [DATA_W-1:0] wakePulse,
  output logic [DATA_W-1:0] haltPulse
);

  localparam logic [DATA_W-1:0] VP_MASK = vpMask(NUM_VP);

  // R10: configuration checks at elaboration
  if (NUM_VP < 1 || NUM_VP > DATA_W) begin : g_bad_count
    $error("runstop_ctrl: NUM_VP must be 1..64");
  end
  if ((START_SET & ~VP_MASK) != '0) begin : g_bad_start
    $error("runstop_ctrl: START_SET names processors at or above NUM_VP");
  end

  ctrl_t             ctrl;
  logic [DATA_W-1:0] running;

  runstop_control #(.ADDR_W(ADDR_W)) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .rspValid (rspValid),
    .ctrl     (ctrl)
  );

  runstop_datapath #(.NUM_VP(NUM_VP), .START_SET(START_SET)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .wdata     (reqWdata),
    .running   (running),
    .wakePulse (wakePulse),
    .haltPulse (haltPulse),
    .rdata     (rspRdata)
  );

  // R8: read data outside a response is always zero
  a_r8_rdata_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (rspRdata == '0));

endmodule

// File: tb/runstop_ctrl_bench.sv
module runstop_ctrl_bench;

  localparam int          NV    = 6;
  localparam logic [63:0] START = 64'h5;
  localparam logic [63:0] MASK  = 64'h3F;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [63:0] reqWdata = '0;
  logic        reqReady, rspValid;
  logic [63:0] rspRdata, wakePulse, haltPulse;

  always #2.5 clk = ~clk;  // 200 MHz

  runstop_ctrl #(.NUM_VP(NV), .START_SET(START), .ADDR_W(16)) u_runstop_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata),
    .wakePulse(wakePulse), .haltPulse(haltPulse)
  );

  typedef struct {
    string       req;
    logic [63:0] wake;
    logic [63:0] halt;
    logic [63:0] rdata;
    bit          rspV;
  } item_t;

  item_t       expQ[$];
  int          nCmp = 0;
  int          nBad = 0;
  logic [63:0] model = '0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: one expected item per cycle, sampled 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        chk(it.req, "wakePulse", wakePulse, it.wake);
        chk(it.req, "haltPulse", haltPulse, it.halt);
        chk(it.req, "rspValid", 64'(rspValid), 64'(it.rspV));
        if (it.rspV) chk(it.req, "rspRdata", rspRdata, it.rdata);
        chk("R2", "reqReady", 64'(reqReady), 64'd1);
      end
    end
  end

  function automatic bit isRun(input logic [15:0] a);
    return a == 16'h2000 || a == 16'h4000;
  endfunction
  function automatic bit isStop(input logic [15:0] a);
    return a == 16'h2008 || a == 16'h4008;
  endfunction
  function automatic bit isStat(input logic [15:0] a);
    return a == 16'h2010 || a == 16'h4010;
  endfunction

  task automatic pushExp(input string req, input logic [63:0] w,
                         input logic [63:0] h, input logic [63:0] rd, input bit rv);
    item_t it;
    it.req = req; it.wake = w; it.halt = h; it.rdata = rd; it.rspV = rv;
    expQ.push_back(it);
  endtask

  task automatic doWrite(input string req, input logic [15:0] a, input logic [63:0] d);
    logic [63:0] w, h;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    w = '0; h = '0;
    if (isRun(a)) begin
      w = d & MASK & ~model;
      model = model | (d & MASK);
    end else if (isStop(a)) begin
      h = d & MASK & model;
      model = model & ~(d & MASK);
    end
    pushExp(req, w, h, '0, 1'b0);
  endtask

  task automatic doRead(input string req, input logic [15:0] a);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a; reqWdata = '0;
    pushExp(req, '0, '0, isStat(a) ? model : 64'h0, 1'b1);
  endtask

  task automatic doIdle(input string req);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWdata = '0;
    pushExp(req, '0, '0, '0, 1'b0);
  endtask

  initial begin
    #(5.0 * 20000);
    nBad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    // R1: quiet outputs while reset holds
    repeat (4) @(posedge clk);
    #1;
    chk("R1", "wakePulse", wakePulse, '0);
    chk("R1", "haltPulse", haltPulse, '0);
    chk("R1", "rspValid", 64'(rspValid), 64'd0);
    chk("R1", "reqReady", 64'(reqReady), 64'd0);

    // R2: release reset; start set applied with wake pulses
    @(negedge clk);
    rstN = 1'b1;
    model = START & MASK;
    pushExp("R2", START & MASK, '0, '0, 1'b0);
    doIdle("R9");                          // pulse gone
    doRead("R6", 16'h2010);                // status = start set
    doWrite("R3", 16'h2000, 64'h7);        // only bit1 newly wakes
    doIdle("R9");
    doWrite("R5", 16'h4000, 64'hFFC0);     // high bits only: nothing
    doRead("R7", 16'h4010);                // alias sees 0x7
    doWrite("R4", 16'h2008, 64'h21);       // bit0 halts, bit5 idle
    doWrite("R7", 16'h4008, 64'h6);        // other window stops rest
    doWrite("R8", 16'h2018, 64'h3F);       // unmapped write
    doRead("R8", 16'h2018);                // unmapped read -> 0
    doRead("R8", 16'h2010);                // bitmap untouched
    doWrite("R5", 16'h4000, '1);           // all ones masked to 0x3F
    doWrite("R3", 16'h2000, 64'h3F);       // all running: no wake
    doRead("R7", 16'h4010);
    doWrite("R8", 16'h3008, 64'h3F);       // unmapped stop alias
    doRead("R8", 16'h2010);
    doRead("R6", 16'h2000);                // write-only register reads 0
    doIdle("R9");
    doIdle("R9");
    wait (expQ.size() == 0);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule